// File: doc/BRIEF.md
# Status Register and Write-Protection Unit

This unit holds the status byte of a small serial EEPROM and decides, cycle by cycle, whether an array write or a status write may go ahead. It keeps the write-enable latch, a two-bit protection level that fences off the top quarter, the top half or all of a 2048-byte array, and a lock-enable bit that arms an active-low hardware lock pin. The serial shifter upstream decodes commands and hands this unit single-cycle strobes. The shifter also passes the target address and the two new status fields. An external write timer reports the internal programming cycle on `busyIn`.

A status write request is honoured only if `statusWrOk` is high in the same cycle. The new lock-enable and level values are held as pending values. They reach the status byte on the clock edge that sees `busyIn` low after it was high. That same edge clears the write-enable latch, whether the cycle was an array write or a status write. While `busyIn` is high, the status byte reads as all ones, both allow flags are low and every command strobe is dropped.

Top module: `wrprot_status_unit`

## Requirements
- R1: After reset, `statusRead` is 8'h00 and `arrayWrOk` and `statusWrOk` are both 0.
- R2: When idle, `welSetCmd` sets the write-enable latch and `welClrCmd` clears it, seen in `statusRead[1]` one cycle later. If both strobes are high, clear wins. Clear works whatever the level of `hwLockN`.
- R3: While `busyIn` is 1, `statusRead` is 8'hFF and both allow flags are 0. Latch strobes and status write requests in such a cycle have no effect.
- R4: When idle, the status byte is laid out as follows: bit 7 is the lock-enable bit, bits 3:2 are the protection level, bit 1 is the latch and bits 6:4 and bit 0 read 0.
- R5: With a 2048-byte array, the protection level sets the protected range. Level 2'b00 protects nothing. Level 2'b01 protects 0x600–0x7FF. Level 2'b10 protects 0x400–0x7FF. Level 2'b11 protects every address. `arrayWrOk` is high only when the latch is set, `busyIn` is 0 and `targetAddr` is outside the protected range.
- R6: `statusWrOk` is high only when the latch is set, `busyIn` is 0, and the lock is not engaged. The lock is engaged when lock-enable is 1 and `hwLockN` is 0. With lock-enable at 0, a low `hwLockN` has no effect.
- R7: A `statWrReq` sampled while `statusWrOk` is 1 captures `newLockEn` and `newLevel`. Bits 7 and 3:2 of the status byte change only on the edge that sees `busyIn` fall. A request made while the lock is engaged changes nothing.
- R8: Once a status write request has been accepted, later changes on `hwLockN` do not cancel it.
- R9: The clock edge on which `busyIn` is first seen low after being high clears the write-enable latch. This holds for every write cycle.
- R10: While the lock is engaged, array writes to addresses outside the protected range are still allowed when the latch is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| welSetCmd | input | 1 | One-cycle strobe that sets the write-enable latch |
| welClrCmd | input | 1 | One-cycle strobe that clears the write-enable latch |
| statWrReq | input | 1 | One-cycle status write request |
| newLockEn | input | 1 | Lock-enable value for the status write |
| newLevel | input | 2 | Protection level value for the status write |
| hwLockN | input | 1 | Hardware lock pin, active low |
| busyIn | input | 1 | High during the internal programming cycle |
| targetAddr | input | 11 | Array address of the pending write |
| statusRead | output | 8 | Status byte as seen by a status read |
| arrayWrOk | output | 1 | Array write to `targetAddr` is allowed |
| statusWrOk | output | 1 | Status write is allowed |

## Verification
The assertions assume that `busyIn` is a clean level from the write timer, held high for at least one full cycle. They also assume that command strobes last one cycle. The stability check on bits 7 and 3:2 relies on commits happening only on a falling edge of `busyIn`. The directed stimulus drives all inputs on the falling clock edge and raises `busyIn` only after a request has been taken. It holds `busyIn` for several cycles and never pulses a strobe for more than one cycle. Expected values are sampled one falling edge after the rising edge that updates the registers.

// File: rtl/wrprot_pkg.sv
package wrprot_pkg;

  typedef enum logic [1:0] {
    LVL_NONE    = 2'b00,
    LVL_QUARTER = 2'b01,
    LVL_HALF    = 2'b10,
    LVL_ALL     = 2'b11
  } protLevel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latchSet;
    logic latchClr;
    logic capture;
    logic commit;
  } wpStrobe_t;

  localparam int STAT_W      = 8;
  localparam int BIT_LOCKEN  = 7;
  localparam int BIT_LVL_HI  = 3;
  localparam int BIT_LVL_LO  = 2;
  localparam int BIT_LATCH   = 1;

endpackage

// File: rtl/wrprot_ctrl.sv
module wrprot_ctrl
  import wrprot_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      welSetCmd,
  input  logic      welClrCmd,
  input  logic      statWrReq,
  input  logic      busyIn,
  input  logic      statusWrOk,
  output wpStrobe_t strobe
);

  logic busyQ;
  logic pendQ;
  logic busyFall;

  assign busyFall = busyQ && !busyIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      pendQ <= 1'b0;
    end else begin
      busyQ <= busyIn;
      if (busyFall)
        pendQ <= 1'b0;
      else if (statWrReq && statusWrOk)
        pendQ <= 1'b1;
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.commit   = busyFall && pendQ;
    strobe.capture  = statWrReq && statusWrOk && !busyFall;
    // end of any programming cycle or an idle clear command drops the latch
    strobe.latchClr = busyFall || (welClrCmd && !busyIn);
    strobe.latchSet = welSetCmd && !busyIn;
  end

endmodule

// File: rtl/wrprot_datapath.sv
module wrprot_datapath
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  wpStrobe_t         strobe,
  input  logic              newLockEn,
  input  logic [1:0]        newLevel,
  input  logic              hwLockN,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [STAT_W-1:0] statusRead,
  output logic              arrayWrOk,
  output logic              statusWrOk
);

  localparam int DEPTH        = 1 << ADDR_W;
  localparam int QUARTER_BASE = DEPTH - DEPTH / 4;
  localparam int HALF_BASE    = DEPTH / 2;
  localparam logic [ADDR_W-1:0] Q_BASE = ADDR_W'(QUARTER_BASE);
  localparam logic [ADDR_W-1:0] H_BASE = ADDR_W'(HALF_BASE);

  logic       latchQ;
  logic       lockEnQ;
  protLevel_t levelQ;
  logic       pendLockEn;
  protLevel_t pendLevel;
  logic       inFence;
  logic       lockEngaged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ     <= 1'b0;
      lockEnQ    <= 1'b0;
      levelQ     <= LVL_NONE;
      pendLockEn <= 1'b0;
      pendLevel  <= LVL_NONE;
    end else begin
      if (strobe.latchClr)
        latchQ <= 1'b0;
      else if (strobe.latchSet)
        latchQ <= 1'b1;
      if (strobe.capture) begin
        pendLockEn <= newLockEn;
        pendLevel  <= protLevel_t'(newLevel);
      end
      if (strobe.commit) begin
        lockEnQ <= pendLockEn;
        levelQ  <= pendLevel;
      end
    end
  end

  always_comb begin
    unique case (levelQ)
      LVL_NONE:    inFence = 1'b0;
      LVL_QUARTER: inFence = (targetAddr >= Q_BASE);
      LVL_HALF:    inFence = (targetAddr >= H_BASE);
      LVL_ALL:     inFence = 1'b1;
      default:     inFence = 1'b1;
    endcase
  end

  assign lockEngaged = lockEnQ && !hwLockN;
  assign arrayWrOk   = latchQ && !busyIn && !inFence;
  assign statusWrOk  = latchQ && !busyIn && !lockEngaged;

  always_comb begin
    if (busyIn) begin
      statusRead = '1;
    end else begin
      statusRead = '0;
      statusRead[BIT_LOCKEN] = lockEnQ;
      statusRead[BIT_LVL_HI:BIT_LVL_LO] = levelQ;
      statusRead[BIT_LATCH] = latchQ;
    end
  end

endmodule

// File: rtl/wrprot_status_unit.sv
module wrprot_status_unit
  import wrprot_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              welSetCmd,
  input  logic              welClrCmd,
  input  logic              statWrReq,
  input  logic              newLockEn,
  input  logic [1:0]        newLevel,
  input  logic              hwLockN,
  input  logic              busyIn,
  input  logic [ADDR_W-1:0] targetAddr,
  output logic [7:0]        statusRead,
  output logic              arrayWrOk,
  output logic              statusWrOk
);

  wpStrobe_t strobe;

  wrprot_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .welSetCmd  (welSetCmd),
    .welClrCmd  (welClrCmd),
    .statWrReq  (statWrReq),
    .busyIn     (busyIn),
    .statusWrOk (statusWrOk),
    .strobe     (strobe)
  );

  wrprot_datapath #(.ADDR_W(ADDR_W)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .newLockEn  (newLockEn),
    .newLevel   (newLevel),
    .hwLockN    (hwLockN),
    .busyIn     (busyIn),
    .targetAddr (targetAddr),
    .statusRead (statusRead),
    .arrayWrOk  (arrayWrOk),
    .statusWrOk (statusWrOk)
  );

endmodule

// File: rtl/wrprot_status_checker.sv
module wrprot_status_checker (
  input logic       clk,
  input logic       rstN,
  input logic       hwLockN,
  input logic       busyIn,
  input logic [7:0] statusRead,
  input logic       arrayWrOk,
  input logic       statusWrOk
);

  // R3: nothing may be written during a programming cycle
  a_r3_no_allow_busy: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |-> (!arrayWrOk && !statusWrOk));

  // R4: spare bits and ready bit read zero when idle
  a_r4_idle_spares_zero: assert property (@(posedge clk) disable iff (!rstN)
    !busyIn |-> (statusRead[6:4] == 3'b000 && !statusRead[0]));

  // R7: lock-enable and level move only right after a busy fall
  a_r7_fields_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!busyIn && !$past(busyIn) && !$past(busyIn, 2)) |->
      ($stable(statusRead[7]) && $stable(statusRead[3:2])));

  // R9: latch is clear after a programming cycle ends
  a_r9_latch_drops: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyIn) |=> (busyIn || !statusRead[1]));

  // R6: engaged lock forbids status writes
  a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    (!busyIn && statusRead[7] && !hwLockN) |-> !statusWrOk);

  // R5: full protection forbids all array writes
  a_r5_full_fence: assert property (@(posedge clk) disable iff (!rstN)
    (!busyIn && statusRead[3:2] == 2'b11) |-> !arrayWrOk);

endmodule

bind wrprot_status_unit wrprot_status_checker uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hwLockN    (hwLockN),
  .busyIn     (busyIn),
  .statusRead (statusRead),
  .arrayWrOk  (arrayWrOk),
  .statusWrOk (statusWrOk)
);

// File: tb/wrprot_status_unit_test.sv
`timescale 1ns/1ps
module wrprot_status_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        welSetCmd = 1'b0;
  logic        welClrCmd = 1'b0;
  logic        statWrReq = 1'b0;
  logic        newLockEn = 1'b0;
  logic [1:0]  newLevel = 2'b00;
  logic        hwLockN = 1'b1;
  logic        busyIn = 1'b0;
  logic [10:0] targetAddr = 11'h000;
  logic [7:0]  statusRead;
  logic        arrayWrOk;
  logic        statusWrOk;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  wrprot_status_unit uut (
    .clk(clk), .rstN(rstN), .welSetCmd(welSetCmd), .welClrCmd(welClrCmd),
    .statWrReq(statWrReq), .newLockEn(newLockEn), .newLevel(newLevel),
    .hwLockN(hwLockN), .busyIn(busyIn), .targetAddr(targetAddr),
    .statusRead(statusRead), .arrayWrOk(arrayWrOk), .statusWrOk(statusWrOk)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic setLatch();
    welSetCmd = 1'b1; tick(); welSetCmd = 1'b0; tick();
  endtask

  // busy cycle: raise, hold, release, then one edge to commit
  task automatic runCycle(input bit dropLockMid);
    busyIn = 1'b1; tick();
    if (dropLockMid) hwLockN = 1'b0;
    tick(); tick();
    busyIn = 1'b0; tick();
  endtask

  task automatic statusWrite(input logic le, input logic [1:0] lv);
    setLatch();
    newLockEn = le; newLevel = lv; statWrReq = 1'b1; tick();
    statWrReq = 1'b0;
    runCycle(1'b0);
  endtask

  task automatic testReset();
    chk("R1 status", statusRead, 8'h00);
    chk("R1 arrayOk", {7'd0, arrayWrOk}, 8'd0);
    chk("R1 statusOk", {7'd0, statusWrOk}, 8'd0);
  endtask

  task automatic testLatch();
    setLatch();
    chk("R2 set", statusRead, 8'h02);
    chk("R4 layout latch", statusRead & 8'h71, 8'h00);
    hwLockN = 1'b0;
    welClrCmd = 1'b1; tick(); welClrCmd = 1'b0; tick();
    chk("R2 clear under lock", statusRead, 8'h00);
    hwLockN = 1'b1;
    welSetCmd = 1'b1; welClrCmd = 1'b1; tick();
    welSetCmd = 1'b0; welClrCmd = 1'b0; tick();
    chk("R2 clear wins", statusRead, 8'h00);
  endtask

  task automatic testBusy();
    busyIn = 1'b1; tick();
    chk("R3 all ones", statusRead, 8'hFF);
    welSetCmd = 1'b1; tick(); welSetCmd = 1'b0;
    chk("R3 no allow", {6'd0, arrayWrOk, statusWrOk}, 8'd0);
    busyIn = 1'b0; tick(); tick();
    chk("R3 set ignored", statusRead, 8'h00);
  endtask

  task automatic testLevels();
    for (int lv = 0; lv < 4; lv++) begin
      statusWrite(1'b0, 2'(lv));
      chk("R7 level commit", statusRead, 8'(lv << 2));
      chk("R9 latch cleared", {7'd0, statusRead[1]}, 8'd0);
      setLatch();
      for (int k = 0; k < 4; k++) begin
        logic [10:0] a;
        logic exp;
        a = (k == 0) ? 11'h3FF : (k == 1) ? 11'h5FF : (k == 2) ? 11'h600 : 11'h7FF;
        exp = (lv == 0) ? 1'b1 : (lv == 1) ? (a < 11'h600) : (lv == 2) ? (a < 11'h400) : 1'b0;
        targetAddr = a; #1;
        chk("R5 fence", {7'd0, arrayWrOk}, {7'd0, exp});
      end
      welClrCmd = 1'b1; tick(); welClrCmd = 1'b0; tick();
    end
    statusWrite(1'b0, 2'b00);
  endtask

  task automatic testGroundedPin();
    hwLockN = 1'b0;
    setLatch();
    chk("R6 pin ignored when disabled", {7'd0, statusWrOk}, 8'd1);
    statusWrite(1'b0, 2'b10);
    chk("R6 write under low pin", statusRead, 8'h08);
    hwLockN = 1'b1;
    statusWrite(1'b0, 2'b00);
  endtask

  task automatic testLock();
    statusWrite(1'b1, 2'b01);
    chk("R4 lock-enable bit", statusRead, 8'h84);
    hwLockN = 1'b0;
    setLatch();
    chk("R6 lock blocks", {7'd0, statusWrOk}, 8'd0);
    targetAddr = 11'h5FF; #1;
    chk("R10 outside fence ok", {7'd0, arrayWrOk}, 8'd1);
    targetAddr = 11'h600; #1;
    chk("R10 inside fence blocked", {7'd0, arrayWrOk}, 8'd0);
    newLockEn = 1'b0; newLevel = 2'b00; statWrReq = 1'b1; tick();
    statWrReq = 1'b0;
    runCycle(1'b0);
    chk("R7 locked request dropped", statusRead, 8'h84);
    hwLockN = 1'b1;
    setLatch();
    newLockEn = 1'b1; newLevel = 2'b11; statWrReq = 1'b1; tick();
    statWrReq = 1'b0;
    runCycle(1'b1);
    chk("R8 late lock no cancel", statusRead, 8'h8C);
    hwLockN = 1'b1;
    statusWrite(1'b0, 2'b00);
    chk("R7 unlock restore", statusRead, 8'h00);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    testReset();
    rstN = 1'b1; tick();
    testReset();
    testLatch();
    testBusy();
    testLevels();
    testGroundedPin();
    testLock();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule